// File: doc/BRIEF.md
# Page-Wrapping Write Buffer for a Byte-Addressed Nonvolatile Array

This block sits between a serial write front end and a small byte array. A transfer begins with a start pulse that carries a byte address. Each data byte that follows goes into a small page buffer at the current pointer. Only the in-page offset of that pointer advances. Once the last byte of a page is written, the next byte goes to the first byte of the same page. This happens both when the transfer crosses a page boundary and when more bytes arrive than the page holds. In either case the earlier buffered bytes are overwritten. A per-offset valid mask records which buffer slots were loaded.

A commit request copies only the loaded slots into the array. If the protect input is high when the commit arrives, the commit is dropped and the array is left untouched. The busy output stays high for the copy and for a programmable write-cycle wait. While it is high, start, byte and commit inputs are ignored. A synchronous array model with one read port is part of the top, so the stored contents can be observed. The page size must be a power of two.

Top module: `pgbuf_top`

## Requirements
- R1: After reset, busy_o is low, the valid mask is empty, and every array location reads as 0x00.
- R2: An accepted start_i loads the pointer from start_addr_i and empties the valid mask. A byte accepted in the same cycle is stored at start_addr_i.
- R3: Each accepted byte is stored at the current pointer offset. The offset then rises by one and the page bits (address bits above the low log2(PAGE_BYTES) bits) stay the same.
- R4: If more than PAGE_BYTES bytes arrive before a commit, the offset rolls over and the later bytes replace the earlier ones. The last byte sent to each offset is the one committed.
- R5: A transfer whose start offset plus length passes the end of a page continues at offset 0 of that same page, never in the next page.
- R6: A commit writes only the offsets loaded since the last start or commit. All other locations, including those in neighbouring pages, keep their values.
- R7: When wprot_i is high at the cycle a commit is accepted, no array location changes, busy_o stays low, and the valid mask is emptied.
- R8: After an unprotected commit, busy_o is high for exactly PAGE_BYTES + WR_CYCLES cycles.
- R9: While busy_o is high, start_i, byte_valid_i and commit_i have no effect: the pointer, mask and buffer keep their values.
- R10: The valid mask is empty after every commit. A later commit never rewrites bytes left in the buffer from an earlier transfer.
- R11: A transfer of one byte writes exactly that one location.
- R12: rd_data_o shows the array contents at the rd_addr_i sampled on the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new transfer at start_addr_i |
| start_addr_i | input | ADDR_W | First byte address of the transfer |
| byte_valid_i | input | 1 | A data byte is presented this cycle |
| byte_data_i | input | DATA_W | Data byte |
| commit_i | input | 1 | Copy buffered bytes into the array |
| wprot_i | input | 1 | Write protect; high drops the commit |
| busy_o | output | 1 | Copy or write-cycle wait in progress |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | DATA_W | Registered array read data |

## Verification
The assertions assume that start_i and commit_i are never high in the same cycle, and that a byte is not presented in the cycle of a commit. The bench drives each transfer as a start (with the first byte), then the remaining bytes, then a separate commit cycle, so these cases never arise. The busy-window assertion also assumes WR_CYCLES is at least one, which the bench configuration meets. The sweep covers every start offset with lengths of 1 to 10. A separate commit sent while busy checks that commits arriving during busy are dropped, rather than relying on the stimulus never producing them.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COPY = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_t;

    // next slot inside a page of n entries
    function automatic int unsigned wrap_inc(int unsigned x, int unsigned n);
        return (x + 1) % n;
    endfunction

endpackage

// File: rtl/pgbuf_collect.sv
module pgbuf_collect #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = ADDR_W - OFF_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              busy,
    input  logic                              start_acc,
    input  logic [ADDR_W-1:0]                 start_addr,
    input  logic                              byte_acc,
    input  logic [DATA_W-1:0]                 byte_data,
    input  logic                              commit_acc,
    output logic [PG_W-1:0]                   page_o,
    output logic [PAGE_BYTES-1:0]             mask_o,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_o
);
    logic [PG_W-1:0]                   page_q;
    logic [OFF_W-1:0]                  off_q;
    logic [PAGE_BYTES-1:0]             mask_q;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_q;

    logic [OFF_W-1:0]      off_b;
    logic [PAGE_BYTES-1:0] mask_b;
    logic [PAGE_BYTES-1:0] mask_set;

    always_comb begin
        off_b  = start_acc ? start_addr[OFF_W-1:0] : off_q;
        mask_b = start_acc ? '0 : mask_q;
        mask_set = mask_b;
        mask_set[off_b] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            off_q  <= '0;
            mask_q <= '0;
            buf_q  <= '0;
        end else if (commit_acc) begin
            mask_q <= '0;
        end else begin
            if (start_acc) begin
                page_q <= start_addr[ADDR_W-1:OFF_W];
                off_q  <= start_addr[OFF_W-1:0];
                mask_q <= '0;
            end
            if (byte_acc) begin
                buf_q[off_b] <= byte_data;
                mask_q       <= mask_set;
                off_q        <= OFF_W'(pgbuf_pkg::wrap_inc(int'(off_b), PAGE_BYTES));
            end
        end
    end

    assign page_o = page_q;
    assign mask_o = mask_q;
    assign buf_o  = buf_q;

    // R3
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        byte_acc && !start_acc && !commit_acc |=> page_q == $past(page_q));
    // R3
    slot_load_chk: assert property (@(posedge clk) disable iff (rst)
        byte_acc && !start_acc && !commit_acc |=> mask_q[$past(off_q)] && buf_q[$past(off_q)] == $past(byte_data));
    // R10
    mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
        commit_acc |=> mask_q == '0);
    // R9
    busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mask_q) && $stable(off_q) && $stable(page_q) && $stable(buf_q));
endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 8,
    parameter int WR_CYCLES  = 16,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = ADDR_W - OFF_W,
    localparam int CNT_W     = $clog2(WR_CYCLES + 1),
    localparam int TOTAL     = PAGE_BYTES + WR_CYCLES,
    localparam int RUN_W     = $clog2(TOTAL + 2)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              commit_acc,
    input  logic                              wprot,
    input  logic [PG_W-1:0]                   page_i,
    input  logic [PAGE_BYTES-1:0]             mask_i,
    input  logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_i,
    output logic                              busy_o,
    output logic                              we_o,
    output logic [ADDR_W-1:0]                 waddr_o,
    output logic [DATA_W-1:0]                 wdata_o
);
    import pgbuf_pkg::*;

    seq_state_t            st_q;
    logic [OFF_W-1:0]      idx_q;
    logic [CNT_W-1:0]      wcnt_q;
    logic [PAGE_BYTES-1:0] cmask_q;
    logic [PG_W-1:0]       cpage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            idx_q   <= '0;
            wcnt_q  <= '0;
            cmask_q <= '0;
            cpage_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (commit_acc && !wprot) begin
                        st_q    <= ST_COPY;
                        idx_q   <= '0;
                        cmask_q <= mask_i;
                        cpage_q <= page_i;
                    end
                end
                ST_COPY: begin
                    if (idx_q == OFF_W'(PAGE_BYTES - 1)) begin
                        st_q   <= ST_WAIT;
                        wcnt_q <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (wcnt_q == CNT_W'(WR_CYCLES - 1)) st_q <= ST_IDLE;
                    else wcnt_q <= wcnt_q + 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o  = (st_q != ST_IDLE);
    assign we_o    = (st_q == ST_COPY) && cmask_q[idx_q];
    assign waddr_o = {cpage_q, idx_q};
    assign wdata_o = buf_i[idx_q];

    // length of the current busy window, for the window check
    logic [RUN_W-1:0] run_q;
    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else if (busy_o) run_q <= run_q + 1'b1;
        else run_q <= '0;
    end

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> run_q == RUN_W'(TOTAL));
    // R7
    protect_drop_chk: assert property (@(posedge clk) disable iff (rst)
        commit_acc && wprot && !busy_o |=> !busy_o);
    // R6
    write_in_page_chk: assert property (@(posedge clk) disable iff (rst)
        we_o |=> busy_o);
endmodule

// File: rtl/pgbuf_array.sv
module pgbuf_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rdata <= '0;
        end else begin
            if (we) mem_q[waddr] <= wdata;
            rdata <= mem_q[raddr];
        end
    end
endmodule

// File: rtl/pgbuf_top.sv
module pgbuf_top #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 8,
    parameter int WR_CYCLES  = 16,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              byte_valid_i,
    input  logic [DATA_W-1:0] byte_data_i,
    input  logic              commit_i,
    input  logic              wprot_i,
    output logic              busy_o,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic                              busy;
    logic                              start_acc, byte_acc, commit_acc;
    logic [PG_W-1:0]                   page;
    logic [PAGE_BYTES-1:0]             mask;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] bufd;
    logic                              we;
    logic [ADDR_W-1:0]                 waddr;
    logic [DATA_W-1:0]                 wdata;

    assign start_acc  = start_i      && !busy;
    assign byte_acc   = byte_valid_i && !busy;
    assign commit_acc = commit_i     && !busy;

    pgbuf_collect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) collect_i (
        .clk(clk), .rst(rst), .busy(busy),
        .start_acc(start_acc), .start_addr(start_addr_i),
        .byte_acc(byte_acc), .byte_data(byte_data_i),
        .commit_acc(commit_acc),
        .page_o(page), .mask_o(mask), .buf_o(bufd)
    );

    pgbuf_commit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
                   .WR_CYCLES(WR_CYCLES)) commit_i_blk (
        .clk(clk), .rst(rst), .commit_acc(commit_acc), .wprot(wprot_i),
        .page_i(page), .mask_i(mask), .buf_i(bufd),
        .busy_o(busy), .we_o(we), .waddr_o(waddr), .wdata_o(wdata)
    );

    pgbuf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
        .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(rd_addr_i), .rdata(rd_data_o)
    );

    assign busy_o = busy;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> !busy_o && mask == '0);
endmodule

// File: tb/pgbuf_top_tb_top.sv
module pgbuf_top_tb_top;
    localparam int AW = 8, DW = 8, PB = 8, WR = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 0, byte_valid_i = 0, commit_i = 0, wprot_i = 0;
    logic [AW-1:0] start_addr_i = '0, rd_addr_i = '0;
    logic [DW-1:0] byte_data_i = '0;
    logic busy_o;
    logic [DW-1:0] rd_data_o;

    int total = 0, bad = 0;
    logic [7:0] ref_mem [256];

    always #2 clk = ~clk;

    pgbuf_top #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WR_CYCLES(WR)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
        .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
        .commit_i(commit_i), .wprot_i(wprot_i), .busy_o(busy_o),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic read_byte(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk) rd_addr_i = a;
        @(negedge clk) v = rd_data_o;
    endtask

    task automatic check_loc(input logic [7:0] a, input string tag);
        logic [7:0] v;
        read_byte(a, v);
        check(v == ref_mem[a], tag, v, ref_mem[a]);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [7:0] pat(int off, int len, int i, int salt);
        return 8'((off * 37 + len * 11 + i * 5 + salt * 71 + 1) & 255);
    endfunction

    // start with the first byte, then remaining bytes, then commit
    task automatic xfer(input logic [7:0] addr, input int len, input int salt, input bit wp);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            start_i = (i == 0);
            start_addr_i = addr;
            byte_valid_i = 1'b1;
            byte_data_i = pat(addr, len, i, salt);
            if (!wp) ref_mem[{addr[7:3], 3'(addr[2:0] + i)}] = byte_data_i;
        end
        @(negedge clk);
        start_i = 0; byte_valid_i = 0;
        commit_i = 1; wprot_i = wp;
        @(negedge clk);
        commit_i = 0; wprot_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] v;
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
        check_loc(8'h00, "R1 array clear");
        check_loc(8'h5A, "R1 array clear");
        check_loc(8'hFF, "R12 read port");

        // sweep every start offset and lengths up to 10
        for (int off = 0; off < PB; off++) begin
            for (int len = 1; len <= 10; len++) begin
                logic [4:0] pg;
                logic [7:0] base;
                string tag;
                pg = 5'((off * 10 + len) % 32);
                base = {pg, 3'b000};
                xfer(base + 8'(off), len, off + len, 1'b0);
                count_busy(n);
                check(n == PB + WR, "R8 busy length", n, PB + WR);
                if (len > PB) tag = "R4 rollover";
                else if (off + len > PB) tag = "R5 page wrap";
                else if (len == 1) tag = "R11 single byte";
                else tag = "R3 sequential";
                for (int k = 0; k < PB; k++) check_loc(base + 8'(k), tag);
                check_loc(base - 8'd1, "R6 lower neighbour");
                check_loc(base + 8'd8, "R6 upper neighbour");
            end
        end

        // R7 protected commit on page 3
        xfer(8'h1A, 4, 99, 1'b1);
        check(busy_o == 1'b0, "R7 no busy when protected", busy_o, 0);
        for (int k = 0; k < PB; k++) check_loc(8'h18 + 8'(k), "R7 page untouched");
        // R10 stale buffer from protected commit must not reach the array
        xfer(8'h1C, 1, 7, 1'b0);
        count_busy(n);
        check(n == PB + WR, "R8 busy length", n, PB + WR);
        for (int k = 0; k < PB; k++) check_loc(8'h18 + 8'(k), "R10 only new byte written");

        // R9 inputs during busy are dropped; R2 start loads the pointer
        xfer(8'h28, 2, 55, 1'b0);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            start_i = (c == 0); start_addr_i = 8'h30;
            byte_valid_i = 1'b1; byte_data_i = 8'hE0 + 8'(c);
            commit_i = (c == 3);
        end
        @(negedge clk);
        start_i = 0; byte_valid_i = 0; commit_i = 0;
        count_busy(n);
        check(n == PB + WR - 7, "R9 busy not extended", n, PB + WR - 7);
        // commit with empty mask: nothing written
        @(negedge clk) commit_i = 1;
        @(negedge clk) commit_i = 0;
        count_busy(n);
        for (int k = 0; k < PB; k++) check_loc(8'h30 + 8'(k), "R9 page 6 untouched");
        for (int k = 0; k < PB; k++) check_loc(8'h28 + 8'(k), "R9 page 5 intact");
        // pointer kept: next byte without start lands at 0x2A
        @(negedge clk) byte_valid_i = 1; byte_data_i = 8'hC3;
        @(negedge clk) byte_valid_i = 0; commit_i = 1;
        @(negedge clk) commit_i = 0;
        count_busy(n);
        ref_mem[8'h2A] = 8'hC3;
        for (int k = 0; k < PB; k++) check_loc(8'h28 + 8'(k), "R2 pointer kept");
        read_byte(8'h2A, v);
        check(v == 8'hC3, "R3 byte at pointer", v, 8'hC3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule